// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a 16-bit offset into a 20-bit physical address. It holds four 16-bit segment registers: code, data, stack and extra. For each request it picks one of them from the access kind and an optional override. The chosen segment value is shifted left by four bits and added to the offset. The sum is kept to 20 bits, which gives a 1 MB space. The block also produces the two byte-lane signals that a 16-bit data bus needs: an active-low high-byte enable and address bit zero.

A caller presents one request per cycle. Each request carries the access kind, the offset, the access size and an override. The registered result appears one cycle later. A word access at an odd offset cannot be done in one bus transfer, so it becomes two byte transfers. The odd byte comes out first and the byte at offset+1 follows in the next cycle. During that second cycle the block reports that it is not ready, and it takes no new request. The segment registers are loaded through a separate write port.

Top module: `seg_addr_gen`

## Requirements
- R1: While reset is low, and after it is released, all four segment registers are zero, `out_valid` is 0 and `req_ready` is 1.
- R2: The physical address is ((segment << 4) + offset) mod 2^20. For example, segment 0x1005 with offset 0x5555 gives 0x155A5, and segment 0xFFFF with offset 0xFFFF gives 0x0FFEF. `a0` always equals bit 0 of the address.
- R3: `req_kind` is coded as follows: 0 is an opcode fetch and uses the code segment, 1 is a stack access and uses the stack segment, 3 is a string destination and uses the extra segment. For these three kinds the override inputs have no effect.
- R4: `req_kind` 2 is a data access. It uses the data segment when `ovr_valid` is 0. When `ovr_valid` is 1 it uses the segment named by `ovr_seg`.
- R5: Segments are numbered 0 = code, 1 = data, 2 = stack, 3 = extra, and `seg_wsel` and `ovr_seg` both use this numbering. A write with `seg_we` high loads `seg_wdata` into the selected register at the clock edge. A request in the same cycle uses the value from before the write, and later requests use the new value.
- R6: The byte lanes follow `req_word` and bit 0 of the offset. A word at an even offset gives `bhe_n`=0 and `a0`=0. A byte at an even offset gives `bhe_n`=1 and `a0`=0. A byte at an odd offset gives `bhe_n`=0 and `a0`=1. None of these requests raises `split`.
- R7: A word at an odd offset produces two outputs in consecutive cycles, and both have `split`=1. The first is the odd byte at the offset (`bhe_n`=0, `a0`=1). The second is the byte at offset+1, wrapped to 16 bits and using the same segment (`bhe_n`=1, `a0`=0). `req_ready` is 0 during the cycle in which the first output is shown.
- R8: While `req_ready` is 0, a request is ignored and produces no output.
- R9: The outputs of a request appear exactly one cycle after it is accepted. `out_valid` is 0 in any cycle that follows a cycle with no accepted request and no pending second byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seg_we | input | 1 | Segment register write enable |
| seg_wsel | input | 2 | Segment register to write (0 code, 1 data, 2 stack, 3 extra) |
| seg_wdata | input | 16 | Value to write |
| req_valid | input | 1 | Address request present |
| req_kind | input | 2 | Access kind (0 fetch, 1 stack, 2 data, 3 string destination) |
| ovr_valid | input | 1 | Segment override present |
| ovr_seg | input | 2 | Override segment number |
| req_off | input | 16 | Offset within the segment |
| req_word | input | 1 | 1 = word access, 0 = byte access |
| req_ready | output | 1 | Low while the second byte of a split word is being issued |
| out_valid | output | 1 | Output address valid |
| addr | output | 20 | Physical address |
| bhe_n | output | 1 | High byte enable, active low |
| a0 | output | 1 | Address bit 0 |
| split | output | 1 | Output belongs to a split odd word |

## Verification
The hardest case to reach is a split word whose second byte wraps past offset 0xFFFF, because it needs a word request at the last odd offset of a segment. The bench sets the extra segment to 0xFFFF and issues an override data word at offset 0xFFFF. The second byte must then appear at the segment base, not just above the first byte. While that second byte is pending, the bench also drives a new request and a segment write in the same cycle. It then checks that the request leaves no output and that the pending byte still uses the segment value that was captured.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
  localparam int SEG_W  = 16;
  localparam int OFF_W  = 16;
  localparam int SHIFT  = 4;
  localparam int PA_W   = 20;
  localparam int NSEG   = 4;
  localparam int SEL_W  = $clog2(NSEG);

  typedef enum logic [1:0] {
    ACC_FETCH  = 2'd0,
    ACC_STACK  = 2'd1,
    ACC_DATA   = 2'd2,
    ACC_STRDST = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    SEG_CODE  = 2'd0,
    SEG_DATA  = 2'd1,
    SEG_STACK = 2'd2,
    SEG_EXTRA = 2'd3
  } seg_id_e;
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
  import seg_addr_pkg::*;
#(
  parameter int W = SEG_W,
  parameter int N = NSEG,
  localparam int SW = $clog2(N)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [SW-1:0]       wsel,
  input  logic [W-1:0]        wdata,
  output logic [N-1:0][W-1:0] rd_all
);
  for (genvar i = 0; i < N; i++) begin : g_seg
    logic         en;
    logic [W-1:0] q;
    assign en = we && (wsel == SW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= wdata;
    end
    assign rd_all[i] = q;
  end
endmodule

// File: rtl/seg_select.sv
module seg_select
  import seg_addr_pkg::*;
#(
  parameter int W = SEG_W,
  parameter int N = NSEG,
  localparam int SW = $clog2(N)
) (
  input  logic [N-1:0][W-1:0] segs,
  input  logic [1:0]          kind,
  input  logic                ovr_v,
  input  logic [SW-1:0]       ovr_id,
  output logic [W-1:0]        seg_val
);
  logic [SW-1:0] id;
  always_comb begin
    unique case (acc_kind_e'(kind))
      ACC_FETCH:  id = SW'(SEG_CODE);
      ACC_STACK:  id = SW'(SEG_STACK);
      ACC_STRDST: id = SW'(SEG_EXTRA);
      default:    id = ovr_v ? ovr_id : SW'(SEG_DATA);
    endcase
  end
  assign seg_val = segs[id];
endmodule

// File: rtl/pa_adder.sv
module pa_adder
  import seg_addr_pkg::*;
#(
  parameter int SW_BITS = SEG_W,
  parameter int OW_BITS = OFF_W,
  parameter int SH      = SHIFT,
  parameter int PW      = PA_W,
  localparam int SUM_W  = SW_BITS + SH + 1
) (
  input  logic [SW_BITS-1:0] seg,
  input  logic [OW_BITS-1:0] off,
  output logic [PW-1:0]      pa
);
  logic [SUM_W-1:0] sum;
  always_comb begin
    sum = SUM_W'({seg, {SH{1'b0}}}) + SUM_W'(off);
    pa  = sum[PW-1:0];
  end
endmodule

// File: rtl/lane_seq.sv
module lane_seq
  import seg_addr_pkg::*;
#(
  parameter int SW_BITS = SEG_W,
  parameter int OW_BITS = OFF_W,
  parameter int PW      = PA_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_word,
  input  logic [OW_BITS-1:0] req_off,
  input  logic [SW_BITS-1:0] seg_in,
  input  logic               eff_lsb,
  input  logic [PW-1:0]      pa_in,
  output logic               pend,
  output logic [SW_BITS-1:0] hold_seg,
  output logic [OW_BITS-1:0] hold_off,
  output logic               out_valid,
  output logic [PW-1:0]      addr,
  output logic               bhe_n,
  output logic               a0,
  output logic               split
);
  logic               accept, odd_word;
  logic               pend_d, ov_d, bhe_d, spl_d, a0_d;
  logic [PW-1:0]      addr_d;
  logic [SW_BITS-1:0] hseg_d;
  logic [OW_BITS-1:0] hoff_d;

  always_comb begin
    accept   = req_valid && !pend;
    odd_word = accept && req_word && req_off[0];
    pend_d   = odd_word;
    hseg_d   = odd_word ? seg_in : hold_seg;
    hoff_d   = odd_word ? req_off + OW_BITS'(1) : hold_off;
    ov_d     = accept || pend;
    addr_d   = pa_in;
    a0_d     = eff_lsb;
    if (pend) begin
      bhe_d = 1'b1;
      spl_d = 1'b1;
    end else if (req_word) begin
      bhe_d = 1'b0;
      spl_d = req_off[0];
    end else begin
      bhe_d = ~req_off[0];
      spl_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      pend      <= pend_d;
      out_valid <= ov_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_seg <= '0;
      hold_off <= '0;
    end else if (odd_word) begin
      hold_seg <= hseg_d;
      hold_off <= hoff_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr  <= '0;
      bhe_n <= 1'b1;
      a0    <= 1'b0;
      split <= 1'b0;
    end else if (ov_d) begin
      addr  <= addr_d;
      bhe_n <= bhe_d;
      a0    <= a0_d;
      split <= spl_d;
    end
  end
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
#(
  parameter int SEGW = SEG_W,
  parameter int OFFW = OFF_W,
  parameter int SHW  = SHIFT,
  parameter int PAW  = PA_W,
  parameter int NS   = NSEG,
  localparam int SLW = $clog2(NS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            seg_we,
  input  logic [SLW-1:0]  seg_wsel,
  input  logic [SEGW-1:0] seg_wdata,
  input  logic            req_valid,
  input  logic [1:0]      req_kind,
  input  logic            ovr_valid,
  input  logic [SLW-1:0]  ovr_seg,
  input  logic [OFFW-1:0] req_off,
  input  logic            req_word,
  output logic            req_ready,
  output logic            out_valid,
  output logic [PAW-1:0]  addr,
  output logic            bhe_n,
  output logic            a0,
  output logic            split
);
  logic [NS-1:0][SEGW-1:0] segs;
  logic [SEGW-1:0]         sel_seg, hold_seg, eff_seg;
  logic [OFFW-1:0]         hold_off, eff_off;
  logic [PAW-1:0]          pa;
  logic                    pend;

  seg_regfile #(.W(SEGW), .N(NS)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(seg_we), .wsel(seg_wsel),
    .wdata(seg_wdata), .rd_all(segs)
  );

  seg_select #(.W(SEGW), .N(NS)) u_sel (
    .segs(segs), .kind(req_kind), .ovr_v(ovr_valid),
    .ovr_id(ovr_seg), .seg_val(sel_seg)
  );

  assign eff_seg = pend ? hold_seg : sel_seg;
  assign eff_off = pend ? hold_off : req_off;

  pa_adder #(.SW_BITS(SEGW), .OW_BITS(OFFW), .SH(SHW), .PW(PAW)) u_add (
    .seg(eff_seg), .off(eff_off), .pa(pa)
  );

  lane_seq #(.SW_BITS(SEGW), .OW_BITS(OFFW), .PW(PAW)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_word(req_word),
    .req_off(req_off), .seg_in(sel_seg), .eff_lsb(eff_off[0]), .pa_in(pa),
    .pend(pend), .hold_seg(hold_seg), .hold_off(hold_off),
    .out_valid(out_valid), .addr(addr), .bhe_n(bhe_n), .a0(a0), .split(split)
  );

  assign req_ready = !pend;
endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk #(
  parameter int PAW = 20
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic           req_ready,
  input logic           out_valid,
  input logic [PAW-1:0] addr,
  input logic           bhe_n,
  input logic           a0,
  input logic           split
);
  always @(negedge clk) begin
    if (!rst_n) begin
      p_reset_idle_r1: assert (!out_valid && req_ready)
        else $error("reset state wrong");
    end
  end

  p_a0_tracks_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (a0 == addr[0]));

  p_lane_code_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(bhe_n && a0));

  p_split_second_beat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && split && a0) |=> (out_valid && split && bhe_n && !a0));

  p_split_stalls_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && split && a0) |-> !req_ready);

  p_stall_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> req_ready);

  p_no_req_no_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !req_valid) |=> !out_valid);
endmodule

bind seg_addr_gen seg_addr_gen_chk #(.PAW(PAW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .out_valid(out_valid), .addr(addr), .bhe_n(bhe_n), .a0(a0), .split(split)
);

// File: tb/seg_addr_gen_test.sv
module seg_addr_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        seg_we = 1'b0;
  logic [1:0]  seg_wsel = '0;
  logic [15:0] seg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = '0;
  logic        ovr_valid = 1'b0;
  logic [1:0]  ovr_seg = '0;
  logic [15:0] req_off = '0;
  logic        req_word = 1'b0;
  logic        req_ready, out_valid, bhe_n, a0, split;
  logic [19:0] addr;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  seg_addr_gen uut (
    .clk(clk), .rst_n(rst_n), .seg_we(seg_we), .seg_wsel(seg_wsel),
    .seg_wdata(seg_wdata), .req_valid(req_valid), .req_kind(req_kind),
    .ovr_valid(ovr_valid), .ovr_seg(ovr_seg), .req_off(req_off),
    .req_word(req_word), .req_ready(req_ready), .out_valid(out_valid),
    .addr(addr), .bhe_n(bhe_n), .a0(a0), .split(split)
  );

  // fields: kind[42:41] ovr_v[40] ovr_seg[39:38] word[37] off[36:21] exp_addr[20:1] exp_bhe_n[0]
  // segments used: code 0x1005, data 0x2000, stack 0x3000, extra 0xFFFF
  localparam int NV = 10;
  localparam logic [42:0] VEC [NV] = '{
    {2'd0, 1'b0, 2'd0, 1'b0, 16'h5555, 20'h155A5, 1'b0},
    {2'd0, 1'b1, 2'd1, 1'b0, 16'h5554, 20'h155A4, 1'b1},
    {2'd1, 1'b0, 2'd0, 1'b1, 16'h0010, 20'h30010, 1'b0},
    {2'd1, 1'b1, 2'd3, 1'b1, 16'h0010, 20'h30010, 1'b0},
    {2'd2, 1'b0, 2'd0, 1'b1, 16'h1234, 20'h21234, 1'b0},
    {2'd2, 1'b1, 2'd2, 1'b0, 16'h0001, 20'h30001, 1'b0},
    {2'd2, 1'b1, 2'd0, 1'b0, 16'h0002, 20'h10052, 1'b1},
    {2'd2, 1'b1, 2'd3, 1'b1, 16'hFFFE, 20'h0FFEE, 1'b0},
    {2'd3, 1'b0, 2'd0, 1'b0, 16'h0000, 20'hFFFF0, 1'b1},
    {2'd3, 1'b1, 2'd1, 1'b0, 16'h000F, 20'hFFFFF, 1'b0}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_seg(input logic [1:0] s, input logic [15:0] v);
    @(negedge clk);
    seg_we = 1'b1; seg_wsel = s; seg_wdata = v;
    @(posedge clk);
    @(negedge clk);
    seg_we = 1'b0;
  endtask

  // drive at negedge, result sampled at the following negedge
  task automatic issue(input logic [1:0] k, input logic ov, input logic [1:0] os,
                       input logic w, input logic [15:0] off);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; ovr_valid = ov; ovr_seg = os;
    req_word = w; req_off = off;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!out_valid, "R1 out_valid in reset", 32'(out_valid), 0);
    chk(req_ready, "R1 req_ready in reset", 32'(req_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && req_ready, "R1 idle after reset",
        {30'd0, out_valid, req_ready}, 1);

    // R1: segments start at zero; data offset 0x0123 -> 0x00123
    issue(2'd2, 1'b0, 2'd0, 1'b0, 16'h0123);
    chk(addr == 20'h00123, "R1 segment zero after reset", 32'(addr), 32'h123);

    wr_seg(2'd0, 16'h1005);
    wr_seg(2'd1, 16'h2000);
    wr_seg(2'd2, 16'h3000);
    wr_seg(2'd3, 16'hFFFF);

    // R2 R3 R4 R6 vector table
    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][42:41], VEC[i][40], VEC[i][39:38], VEC[i][37], VEC[i][36:21]);
      chk(out_valid, $sformatf("R9 vec%0d valid", i), 32'(out_valid), 1);
      chk(addr == VEC[i][20:1], $sformatf("R2/R3/R4 vec%0d addr", i),
          32'(addr), 32'(VEC[i][20:1]));
      chk(bhe_n == VEC[i][0], $sformatf("R6 vec%0d bhe_n", i),
          32'(bhe_n), 32'(VEC[i][0]));
      chk(a0 == VEC[i][1], $sformatf("R6 vec%0d a0", i), 32'(a0), 32'(VEC[i][1]));
      chk(!split, $sformatf("R6 vec%0d split", i), 32'(split), 0);
    end

    // R9: a cycle with no request gives no output
    @(negedge clk);
    chk(!out_valid, "R9 idle", 32'(out_valid), 0);

    // R7: odd word in data segment 0x2000 at 0x0101
    issue(2'd2, 1'b0, 2'd0, 1'b1, 16'h0101);
    chk(out_valid && split && !bhe_n && a0, "R7 first beat lanes",
        {28'd0, out_valid, split, bhe_n, a0}, 32'hD);
    chk(addr == 20'h20101, "R7 first beat addr", 32'(addr), 32'h20101);
    chk(!req_ready, "R7 ready low", 32'(req_ready), 0);
    @(posedge clk);
    @(negedge clk);
    chk(out_valid && split && bhe_n && !a0, "R7 second beat lanes",
        {28'd0, out_valid, split, bhe_n, a0}, 32'hE);
    chk(addr == 20'h20102, "R7 second beat addr", 32'(addr), 32'h20102);
    chk(req_ready, "R7 ready back", 32'(req_ready), 1);

    // R7 R8: wrap at offset 0xFFFF in extra segment; request + write during stall
    issue(2'd2, 1'b1, 2'd3, 1'b1, 16'hFFFF);
    chk(addr == 20'h0FFEF, "R7 wrap first addr", 32'(addr), 32'h0FFEF);
    req_valid = 1'b1; req_kind = 2'd0; req_word = 1'b0; req_off = 16'h0000;
    seg_we = 1'b1; seg_wsel = 2'd3; seg_wdata = 16'h0100;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; seg_we = 1'b0;
    chk(addr == 20'hFFFF0, "R7 wrap second addr uses held segment",
        32'(addr), 32'hFFFF0);
    chk(bhe_n && !a0, "R7 wrap second lanes", {30'd0, bhe_n, a0}, 2);
    @(posedge clk);
    @(negedge clk);
    chk(!out_valid, "R8 stalled request ignored", 32'(out_valid), 0);

    // R5: write and request in the same cycle
    @(negedge clk);
    seg_we = 1'b1; seg_wsel = 2'd1; seg_wdata = 16'h4000;
    req_valid = 1'b1; req_kind = 2'd2; ovr_valid = 1'b0; req_word = 1'b0;
    req_off = 16'h0000;
    @(posedge clk);
    @(negedge clk);
    seg_we = 1'b0; req_valid = 1'b0;
    chk(addr == 20'h20000, "R5 same-cycle uses old", 32'(addr), 32'h20000);
    issue(2'd2, 1'b0, 2'd0, 1'b0, 16'h0000);
    chk(addr == 20'h40000, "R5 later uses new", 32'(addr), 32'h40000);
    issue(2'd3, 1'b0, 2'd0, 1'b0, 16'h0000);
    chk(addr == 20'h01000, "R5 extra rewritten during stall", 32'(addr), 32'h01000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule